// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit with Extend

This unit does decimal arithmetic on one byte that holds two packed BCD digits. It supports three operations. The first is an add that includes the incoming extend bit. The second is a subtract that takes the extend bit as a borrow. The third negates a source byte against zero, again taking the extend bit as a borrow. The carry or borrow leaving the top digit becomes the new extend and carry flags. The zero flag can only be cleared, never set. Because of this, a string of bytes processed least significant first, with the flags fed back, ends with zero set only if every byte of the string came out zero.

Operands are taken as given. Fetching them, addressing and memory sequencing are left to the surrounding datapath. A request arrives with `valid_in` high. The result and all five flags are captured in registers on that edge and come out with `valid_out` one cycle later. Two flags have no defined meaning for decimal work. They are still driven to fixed values: the negative flag copies result bit 7, and the overflow flag is always 0. Nibbles that are not valid BCD produce an output that is deterministic but carries no meaning.

Top module: `bcd_xalu`

## Requirements
- R1: With `op` = 2'b00 and valid BCD operands, `result` holds the two low decimal digits of dst + src + X, and the carry out is 1 exactly when that sum is 100 or more.
- R2: With `op` = 2'b01, `result` holds (dst − src − X) mod 100 in BCD, and the borrow out is 1 exactly when dst − src − X is negative.
- R3: With `op[1]` = 1, `result` holds (0 − src − X) mod 100 in BCD, with a borrow out whenever src + X is nonzero. The `dst_in` value has no effect on any output.
- R4: `x_out` and `c_out` both equal the carry or borrow out of the operation.
- R5: `z_out` is 0 when the result is nonzero. When the result is zero, `z_out` equals `z_in`.
- R6: `n_out` equals bit 7 of `result`, and `v_out` is always 0.
- R7: `valid_out` is high in exactly the cycle after a cycle with `valid_in` high. Without `valid_in`, the result and flags keep their values.
- R8: While `rst` is high, and after it, `valid_out`, `result` and every flag output are 0 until the first request is captured.
- R9: The operation codes are: 2'b00 add, 2'b01 subtract, 2'b10 and 2'b11 both negate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe: operands and op are valid |
| op | input | 2 | Operation code (see R9) |
| dst_in | input | 8 | Destination operand, the minuend or first addend |
| src_in | input | 8 | Source operand |
| x_in | input | 1 | Incoming extend bit |
| z_in | input | 1 | Incoming zero flag |
| valid_out | output | 1 | Result valid, one cycle after the request |
| result | output | 8 | Packed BCD result |
| x_out | output | 1 | Extend flag, the carry or borrow out |
| n_out | output | 1 | Negative flag, result bit 7 |
| z_out | output | 1 | Sticky zero flag |
| v_out | output | 1 | Overflow flag, fixed at 0 |
| c_out | output | 1 | Carry flag, the same as extend |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing, that outputs hold when no request is present, the reset state, that extend matches carry, that the negative flag tracks bit 7 of the result, and the one-way behaviour of the zero flag. The decimal values themselves can only be shown by the bench's scenarios. These include the digit-adjust and carry cases: a sum at or above 100, a borrow past zero, a negate of zero with and without extend, and a negate where the destination operand changes but must have no effect. The bench also runs a series of random BCD operands against an integer decimal model.

// File: rtl/bcd_xalu_pkg.sv
package bcd_xalu_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    BOP_ADDX  = 2'b00,
    BOP_SUBX  = 2'b01,
    BOP_NEGX  = 2'b10,
    BOP_NEGX2 = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_xalu_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [NIB_W-1:0] d,
  output logic             cout
);
  logic [NIB_W:0] raw;
  logic [NIB_W:0] fix;

  always_comb begin
    if (!sub) begin
      raw = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
      if (raw > 5'd9) begin
        fix  = raw + 5'd6;
        cout = 1'b1;
      end else begin
        fix  = raw;
        cout = 1'b0;
      end
    end else begin
      raw = {1'b0, a} - {1'b0, b} - {{NIB_W{1'b0}}, cin};
      if (raw[NIB_W]) begin
        fix  = raw + 5'd10;
        cout = 1'b1;
      end else begin
        fix  = raw;
        cout = 1'b0;
      end
    end
    d = fix[NIB_W-1:0];
  end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_xalu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit u_dig (
      .a    (opa[g*NIB_W +: NIB_W]),
      .b    (opb[g*NIB_W +: NIB_W]),
      .cin  (carry[g]),
      .sub  (sub),
      .d    (sum[g*NIB_W +: NIB_W]),
      .cout (carry[g+1])
    );
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit
  import bcd_xalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         carry,
  input  logic         z_prev,
  output ccr_t         flags
);
  always_comb begin
    flags.x = carry;
    flags.c = carry;
    flags.n = res[W-1];
    flags.v = 1'b0;
    flags.z = z_prev & (res == '0);
  end
endmodule

// File: rtl/bcd_xalu.sv
module bcd_xalu
  import bcd_xalu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = NIB_W * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [1:0]   op,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] src_in,
  input  logic         x_in,
  input  logic         z_in,
  output logic         valid_out,
  output logic [W-1:0] result,
  output logic         x_out,
  output logic         n_out,
  output logic         z_out,
  output logic         v_out,
  output logic         c_out
);
  logic         is_neg;
  logic         is_sub;
  logic [W-1:0] lhs;
  logic [W-1:0] sum;
  logic         carry;
  ccr_t         nxt;

  assign is_neg = op[1];
  assign is_sub = op[1] | op[0];
  assign lhs    = is_neg ? '0 : dst_in;

  bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .opa  (lhs),
    .opb  (src_in),
    .cin  (x_in),
    .sub  (is_sub),
    .sum  (sum),
    .cout (carry)
  );

  bcd_flag_unit #(.W(W)) u_flags (
    .res    (sum),
    .carry  (carry),
    .z_prev (z_in),
    .flags  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
      x_out     <= 1'b0;
      n_out     <= 1'b0;
      z_out     <= 1'b0;
      v_out     <= 1'b0;
      c_out     <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result <= sum;
        x_out  <= nxt.x;
        n_out  <= nxt.n;
        z_out  <= nxt.z;
        v_out  <= nxt.v;
        c_out  <= nxt.c;
      end
    end
  end
endmodule

// File: rtl/bcd_xalu_chk.sv
module bcd_xalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_in,
  input logic [W-1:0] src_in,
  input logic [1:0]   op,
  input logic         x_in,
  input logic         z_in,
  input logic         valid_out,
  input logic [W-1:0] result,
  input logic         x_out,
  input logic         n_out,
  input logic         z_out,
  input logic         v_out,
  input logic         c_out
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(z_out) && $stable(c_out)));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!valid_out && result == '0 && !x_out && !z_out && !c_out));

  a_r4_x_matches_c: assert property (@(posedge clk) disable iff (rst)
    x_out == c_out);

  a_r6_n_tracks_msb: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (n_out == result[W-1] && !v_out));

  a_r5_z_never_set: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !z_in) |=> !z_out);

  a_r5_z_clear_nonzero: assert property (@(posedge clk) disable iff (rst)
    (valid_out && result != '0) |-> !z_out);

  a_r3_neg_zero_src: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op[1] && src_in == '0 && !x_in) |=> (result == '0 && !c_out));
endmodule

bind bcd_xalu bcd_xalu_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .src_in    (src_in),
  .op        (op),
  .x_in      (x_in),
  .z_in      (z_in),
  .valid_out (valid_out),
  .result    (result),
  .x_out     (x_out),
  .n_out     (n_out),
  .z_out     (z_out),
  .v_out     (v_out),
  .c_out     (c_out)
);

// File: tb/bcd_xalu_tb_top.sv
module bcd_xalu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_in = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] dst_in = '0;
  logic [7:0] src_in = '0;
  logic       x_in = 1'b0;
  logic       z_in = 1'b0;
  logic       valid_out;
  logic [7:0] result;
  logic       x_out, n_out, z_out, v_out, c_out;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] res;
    logic       cy;
    logic       z;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] last_res;
  logic       have_last = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_xalu dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op(op),
    .dst_in(dst_in), .src_in(src_in), .x_in(x_in), .z_in(z_in),
    .valid_out(valid_out), .result(result), .x_out(x_out),
    .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
  );

  function automatic int to_dec(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] o, input logic [7:0] a,
                      input logic [7:0] b, input logic x, input logic z,
                      input string tag);
    exp_t e;
    int   v;
    @(negedge clk);
    op = o; dst_in = a; src_in = b; x_in = x; z_in = z; valid_in = 1'b1;
    if (o == 2'b00) begin
      v = to_dec(a) + to_dec(b) + int'(x);
      e.cy = (v >= 100);
      e.res = to_bcd(v % 100);
    end else begin
      v = ((o[1]) ? 0 : to_dec(a)) - to_dec(b) - int'(x);
      e.cy = (v < 0);
      e.res = to_bcd((v + 100) % 100);
    end
    e.z = z & (e.res == 8'h00);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_out) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "valid_out without request", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(result == e.res, e.tag, "result", result, e.res);
          check(x_out == e.cy && c_out == e.cy, "R4", "x/c", {x_out, c_out}, {e.cy, e.cy});
          check(z_out == e.z, "R5", "z", z_out, e.z);
          check(n_out == e.res[7] && v_out == 1'b0, "R6", "n/v", {n_out, v_out}, {e.res[7], 1'b0});
          last_res = result;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check(result == last_res, "R7", "hold without request", result, last_res);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0 && result == 8'h00, "R8", "reset outputs", {valid_out, result}, 0);
    check({x_out, n_out, z_out, v_out, c_out} == 5'b0, "R8", "reset flags",
          {x_out, n_out, z_out, v_out, c_out}, 0);
    @(negedge clk);
    rst = 1'b0;

    send(2'b00, 8'h45, 8'h38, 1'b0, 1'b1, "R1");
    send(2'b00, 8'h99, 8'h01, 1'b0, 1'b1, "R1");
    send(2'b00, 8'h99, 8'h99, 1'b1, 1'b0, "R1");
    send(2'b00, 8'h08, 8'h01, 1'b1, 1'b1, "R1");
    idle(2);
    send(2'b01, 8'h42, 8'h17, 1'b0, 1'b1, "R2");
    send(2'b01, 8'h10, 8'h20, 1'b0, 1'b1, "R2");
    send(2'b01, 8'h00, 8'h00, 1'b1, 1'b1, "R2");
    send(2'b01, 8'h50, 8'h49, 1'b1, 1'b1, "R2");
    idle(1);
    send(2'b10, 8'h00, 8'h01, 1'b0, 1'b1, "R3");
    send(2'b10, 8'h77, 8'h01, 1'b0, 1'b1, "R3");
    send(2'b10, 8'h00, 8'h00, 1'b0, 1'b1, "R3");
    send(2'b10, 8'h55, 8'h00, 1'b1, 1'b1, "R3");
    send(2'b11, 8'h12, 8'h25, 1'b0, 1'b0, "R9");
    send(2'b11, 8'h99, 8'h00, 1'b0, 1'b1, "R9");
    idle(3);
    send(2'b00, 8'h00, 8'h00, 1'b0, 1'b1, "R5");
    send(2'b00, 8'h00, 8'h00, 1'b0, 1'b0, "R5");
    send(2'b01, 8'h33, 8'h33, 1'b0, 1'b1, "R5");
    send(2'b00, 8'h50, 8'h50, 1'b0, 1'b1, "R5");
    idle(2);

    for (int i = 0; i < 80; i++) begin
      logic [7:0] a, b;
      logic [1:0] o;
      a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      o = 2'($urandom_range(0, 3));
      send(o, a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : "R3");
      if ((i % 7) == 3) idle(1);
    end
    idle(4);

    check(sb_q.size() == 0, "R7", "pending results", sb_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule